// File: doc/BRIEF.md
# Clock Source Mode Controller

This block sequences the clock sources of a small processor core. It decides whether the external crystal runs, whether the CPU is clocked from the internal high-speed oscillator or from the crystal, and whether the core is in a halted or stopped sub-state. There are three run states:

- **State 1:** the crystal is off and the CPU runs on the internal oscillator.
- **State 2:** the crystal runs but the CPU still uses the internal oscillator.
- **State 3:** the CPU runs on the crystal.

Software moves between run states with two register bits, a crystal-stop bit and a clock-select bit, which reach the block as write strobes. The block refuses moves that would leave the CPU without a clock, or that would put it on a crystal that has not settled. A settling counter inside the block models the crystal start-up time. HALT and STOP strobes park the core and an interrupt wakes it. Any reset source returns everything to state 1.

Top module: `clksrc_mode_ctrl`

## Requirements
- R1: After `rst`, the outputs are `cpu_on_xtal`=0, `clk_stat`=0, `xtal_en`=0, `hsosc_en`=1, `lsosc_en`=1, `cpu_halted`=0 and `stab_done`=0.
- R2: While running, a crystal-stop write of 0 sets `xtal_en` in the next cycle. A write of 1 made while `clk_stat` is 0 clears `xtal_en` in the next cycle.
- R3: A crystal-stop write of 1 made while `clk_stat` is 1 is ignored, and `xtal_en` stays 1.
- R4: `stab_done` rises exactly STAB_CYCLES cycles after `xtal_en` rises. It falls in the cycle after `xtal_en` is low.
- R5: After a clock-select write of 1, `clk_stat` and `cpu_on_xtal` rise one cycle after `stab_done` is high with the crystal on. Until then they stay 0 and the request remains pending.
- R6: A clock-select write of 0 in state 3 clears `clk_stat` one cycle after the write takes effect, so the status lags by one cycle.
- R7: A HALT strobe sets `cpu_halted` and leaves all oscillator enables and `cpu_on_xtal` unchanged. An interrupt clears `cpu_halted` in the next cycle.
- R8: A STOP strobe sets `cpu_halted` and drives `hsosc_en` and `xtal_en` low. An interrupt returns the core to the run state it left, including state 3.
- R9: On release from STOP with the crystal enabled, the settling counter restarts from zero. `stab_done` is 0 after release and rises STAB_CYCLES cycles later.
- R10: If a HALT or STOP strobe arrives in the same cycle as `irq`, no sub-state is entered.
- R11: Any bit of `rst_src` forces state 1 and the run sub-state in the next cycle, from any state. Bit 0 is the reset pin, bit 1 power-on clear, bit 2 low-voltage detect and bit 3 the watchdog.
- R12: When `lsosc_keep` is 1, `lsosc_en` is 1 in every state. When it is 0, `lsosc_en` is 0 only in STOP.
- R13: If HALT and STOP strobes coincide without an interrupt, STOP is entered.
- R14: Register writes are ignored while `cpu_halted` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_src | input | NUM_RST_SRC | Reset sources: pin, power-on, low-voltage, watchdog |
| lsosc_keep | input | 1 | Option: low-speed oscillator may never stop |
| xtal_stop_wr | input | 1 | Write strobe for the crystal-stop bit |
| xtal_stop_wdata | input | 1 | Value written to the crystal-stop bit |
| clk_sel_wr | input | 1 | Write strobe for the clock-select bit |
| clk_sel_wdata | input | 1 | Value written to the clock-select bit |
| halt_req | input | 1 | HALT instruction strobe |
| stop_req | input | 1 | STOP instruction strobe |
| irq | input | 1 | Interrupt request |
| cpu_on_xtal | output | 1 | CPU clock select, 1 = crystal |
| hsosc_en | output | 1 | Internal high-speed oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| lsosc_en | output | 1 | Internal low-speed oscillator enable |
| cpu_halted | output | 1 | Core is in HALT or STOP |
| clk_stat | output | 1 | Clock-select status, 1 = CPU on crystal |
| stab_done | output | 1 | Crystal settling counter expired |

## Verification
An interrupt and a HALT or STOP strobe can arrive in the same cycle. The bench provokes this by driving `irq` together with `stop_req`, and then together with `halt_req`, for one cycle. It judges the result by `cpu_halted` staying 0 and `hsosc_en` staying 1 in the following cycle. A second collision is a crystal-stop write of 1 while the CPU is on the crystal. The bench provokes it in state 3 and expects `xtal_en` to stay high.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic [1:0] {
    SUB_RUN  = 2'd0,
    SUB_HALT = 2'd1,
    SUB_STOP = 2'd2
  } sub_e;
endpackage

// File: rtl/clksrc_stab_cnt.sv
// Crystal settling counter: runs while the crystal is enabled, restarts from zero otherwise.
module clksrc_stab_cnt #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
      done  <= (cnt_q == LAST);
    end
  end
endmodule

// File: rtl/clksrc_fsm.sv
// Run-state and sub-state sequencer with registered outputs.
module clksrc_fsm
  import clksrc_pkg::*;
#(
  parameter int NUM_RST_SRC = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_RST_SRC-1:0] rst_src,
  input  logic                   lsosc_keep,
  input  logic                   xtal_stop_wr,
  input  logic                   xtal_stop_wdata,
  input  logic                   clk_sel_wr,
  input  logic                   clk_sel_wdata,
  input  logic                   halt_req,
  input  logic                   stop_req,
  input  logic                   irq,
  input  logic                   stab_done,
  output logic                   cpu_on_xtal,
  output logic                   hsosc_en,
  output logic                   xtal_en,
  output logic                   lsosc_en,
  output logic                   cpu_halted,
  output logic                   clk_stat
);
  logic xstop_q, xstop_n;   // crystal-stop bit
  logic sel_q, sel_n;       // requested clock select
  logic stat_q, stat_n;     // completed clock select
  sub_e sub_q, sub_n;
  logic force_st1;

  assign force_st1 = rst | (|rst_src);

  always_comb begin
    xstop_n = xstop_q;
    sel_n   = sel_q;
    stat_n  = stat_q;
    sub_n   = sub_q;
    if (sub_q == SUB_RUN) begin
      if (xtal_stop_wr) begin
        if (!xtal_stop_wdata)
          xstop_n = 1'b0;
        else if (!stat_q)
          xstop_n = 1'b1;
      end
      if (clk_sel_wr)
        sel_n = clk_sel_wdata;
      // Leaving the crystal follows the request; joining it waits for settling.
      stat_n = stat_q ? sel_q : (sel_q & ~xstop_n & stab_done);
      if (!irq) begin
        if (stop_req)
          sub_n = SUB_STOP;
        else if (halt_req)
          sub_n = SUB_HALT;
      end
    end else if (irq) begin
      sub_n = SUB_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (force_st1) begin
      xstop_q     <= 1'b1;
      sel_q       <= 1'b0;
      stat_q      <= 1'b0;
      sub_q       <= SUB_RUN;
      cpu_on_xtal <= 1'b0;
      clk_stat    <= 1'b0;
      hsosc_en    <= 1'b1;
      xtal_en     <= 1'b0;
      lsosc_en    <= 1'b1;
      cpu_halted  <= 1'b0;
    end else begin
      xstop_q     <= xstop_n;
      sel_q       <= sel_n;
      stat_q      <= stat_n;
      sub_q       <= sub_n;
      cpu_on_xtal <= stat_n;
      clk_stat    <= stat_n;
      hsosc_en    <= (sub_n != SUB_STOP);
      xtal_en     <= ~xstop_n & (sub_n != SUB_STOP);
      lsosc_en    <= lsosc_keep | (sub_n != SUB_STOP);
      cpu_halted  <= (sub_n != SUB_RUN);
    end
  end
endmodule

// File: rtl/clksrc_mode_ctrl.sv
module clksrc_mode_ctrl #(
  parameter int NUM_RST_SRC = 4,
  parameter int STAB_CYCLES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_RST_SRC-1:0] rst_src,
  input  logic                   lsosc_keep,
  input  logic                   xtal_stop_wr,
  input  logic                   xtal_stop_wdata,
  input  logic                   clk_sel_wr,
  input  logic                   clk_sel_wdata,
  input  logic                   halt_req,
  input  logic                   stop_req,
  input  logic                   irq,
  output logic                   cpu_on_xtal,
  output logic                   hsosc_en,
  output logic                   xtal_en,
  output logic                   lsosc_en,
  output logic                   cpu_halted,
  output logic                   clk_stat,
  output logic                   stab_done
);
  logic settle_done;

  clksrc_fsm #(.NUM_RST_SRC(NUM_RST_SRC)) fsm_i (
    .clk             (clk),
    .rst             (rst),
    .rst_src         (rst_src),
    .lsosc_keep      (lsosc_keep),
    .xtal_stop_wr    (xtal_stop_wr),
    .xtal_stop_wdata (xtal_stop_wdata),
    .clk_sel_wr      (clk_sel_wr),
    .clk_sel_wdata   (clk_sel_wdata),
    .halt_req        (halt_req),
    .stop_req        (stop_req),
    .irq             (irq),
    .stab_done       (settle_done),
    .cpu_on_xtal     (cpu_on_xtal),
    .hsosc_en        (hsosc_en),
    .xtal_en         (xtal_en),
    .lsosc_en        (lsosc_en),
    .cpu_halted      (cpu_halted),
    .clk_stat        (clk_stat)
  );

  clksrc_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) stab_i (
    .clk  (clk),
    .rst  (rst),
    .run  (xtal_en),
    .done (settle_done)
  );

  assign stab_done = settle_done;
endmodule

// File: rtl/clksrc_mode_ctrl_chk.sv
module clksrc_mode_ctrl_chk #(
  parameter int NUM_RST_SRC = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_RST_SRC-1:0] rst_src,
  input logic                   lsosc_keep,
  input logic                   irq,
  input logic                   hsosc_en,
  input logic                   xtal_en,
  input logic                   lsosc_en,
  input logic                   cpu_halted,
  input logic                   clk_stat,
  input logic                   stab_done
);
  // R3: CPU on the crystal implies the crystal runs (unless stopped)
  p_xtal_kept_r3: assert property (@(posedge clk) disable iff (rst)
    clk_stat |-> (xtal_en || cpu_halted));

  // R4: settling flag clears once the crystal is off
  p_stab_clear_r4: assert property (@(posedge clk) disable iff (rst)
    !xtal_en |=> !stab_done);

  // R5: switching onto the crystal needs a settled crystal
  p_sel_needs_stab_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_stat) |-> $past(stab_done));

  // R8: high-speed oscillator off only inside STOP, with crystal also off
  p_stop_osc_off_r8: assert property (@(posedge clk) disable iff (rst)
    !hsosc_en |-> (cpu_halted && !xtal_en));

  // R10: interrupt in run state wins over sub-state entry
  p_irq_prio_r10: assert property (@(posedge clk) disable iff (rst)
    (irq && !cpu_halted) |=> !cpu_halted);

  // R11: any reset source returns to state 1
  p_rst_src_r11: assert property (@(posedge clk) disable iff (rst)
    (|rst_src) |=> (!clk_stat && !xtal_en && !cpu_halted && hsosc_en));

  // R12: low-speed oscillator never stops when the option is set
  p_lsosc_keep_r12: assert property (@(posedge clk) disable iff (rst)
    lsosc_keep |=> lsosc_en);
endmodule

bind clksrc_mode_ctrl clksrc_mode_ctrl_chk #(.NUM_RST_SRC(NUM_RST_SRC)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .rst_src    (rst_src),
  .lsosc_keep (lsosc_keep),
  .irq        (irq),
  .hsosc_en   (hsosc_en),
  .xtal_en    (xtal_en),
  .lsosc_en   (lsosc_en),
  .cpu_halted (cpu_halted),
  .clk_stat   (clk_stat),
  .stab_done  (stab_done)
);

// File: tb/clksrc_mode_ctrl_tb.sv
`timescale 1ns/1ps
module clksrc_mode_ctrl_tb_top;
  localparam int NSRC = 4;
  localparam int STAB = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] rst_src = '0;
  logic lsosc_keep = 1'b0;
  logic xtal_stop_wr = 1'b0, xtal_stop_wdata = 1'b0;
  logic clk_sel_wr = 1'b0, clk_sel_wdata = 1'b0;
  logic halt_req = 1'b0, stop_req = 1'b0, irq = 1'b0;
  logic cpu_on_xtal, hsosc_en, xtal_en, lsosc_en, cpu_halted, clk_stat, stab_done;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  clksrc_mode_ctrl #(.NUM_RST_SRC(NSRC), .STAB_CYCLES(STAB)) dut_i (
    .clk(clk), .rst(rst), .rst_src(rst_src), .lsosc_keep(lsosc_keep),
    .xtal_stop_wr(xtal_stop_wr), .xtal_stop_wdata(xtal_stop_wdata),
    .clk_sel_wr(clk_sel_wr), .clk_sel_wdata(clk_sel_wdata),
    .halt_req(halt_req), .stop_req(stop_req), .irq(irq),
    .cpu_on_xtal(cpu_on_xtal), .hsosc_en(hsosc_en), .xtal_en(xtal_en),
    .lsosc_en(lsosc_en), .cpu_halted(cpu_halted), .clk_stat(clk_stat),
    .stab_done(stab_done)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic apply_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
  endtask

  task automatic wr_xstop(input logic v);
    xtal_stop_wr = 1'b1; xtal_stop_wdata = v; tick(); xtal_stop_wr = 1'b0;
  endtask

  task automatic wr_sel(input logic v);
    clk_sel_wr = 1'b1; clk_sel_wdata = v; tick(); clk_sel_wr = 1'b0;
  endtask

  task automatic pulse_halt(); halt_req = 1'b1; tick(); halt_req = 1'b0; endtask
  task automatic pulse_stop(); stop_req = 1'b1; tick(); stop_req = 1'b0; endtask
  task automatic pulse_irq();  irq = 1'b1; tick(); irq = 1'b0; endtask

  task automatic goto_state2();
    apply_reset(); wr_xstop(1'b0); repeat (STAB) tick();
  endtask

  task automatic goto_state3();
    apply_reset(); wr_xstop(1'b0); wr_sel(1'b1); repeat (STAB) tick();
  endtask

  task automatic t_reset();
    apply_reset();
    chk("R1 cpu_on_xtal", cpu_on_xtal, 1'b0);
    chk("R1 clk_stat", clk_stat, 1'b0);
    chk("R1 xtal_en", xtal_en, 1'b0);
    chk("R1 hsosc_en", hsosc_en, 1'b1);
    chk("R1 lsosc_en", lsosc_en, 1'b1);
    chk("R1 cpu_halted", cpu_halted, 1'b0);
    chk("R1 stab_done", stab_done, 1'b0);
  endtask

  task automatic t_xtal_start();
    apply_reset();
    wr_xstop(1'b0);
    chk("R2 xtal_en after start", xtal_en, 1'b1);
    repeat (STAB - 1) tick();
    chk("R4 stab_done one cycle early", stab_done, 1'b0);
    tick();
    chk("R4 stab_done on time", stab_done, 1'b1);
    wr_xstop(1'b1);
    chk("R2 xtal_en after stop write", xtal_en, 1'b0);
    tick();
    chk("R4 stab_done cleared", stab_done, 1'b0);
  endtask

  task automatic t_sel_pending();
    apply_reset();
    wr_xstop(1'b0);
    wr_sel(1'b1);
    chk("R5 pending clk_stat", clk_stat, 1'b0);
    repeat (STAB - 1) tick();
    chk("R5 stab seen", stab_done, 1'b1);
    chk("R5 still pending", clk_stat, 1'b0);
    tick();
    chk("R5 clk_stat", clk_stat, 1'b1);
    chk("R5 cpu_on_xtal", cpu_on_xtal, 1'b1);
    // R3: crystal-stop write ignored while on crystal
    wr_xstop(1'b1);
    chk("R3 xtal_en kept", xtal_en, 1'b1);
    tick();
    chk("R3 xtal_en kept later", xtal_en, 1'b1);
    // R6: back to state 2 with one-cycle lag
    wr_sel(1'b0);
    chk("R6 status lags", clk_stat, 1'b1);
    tick();
    chk("R6 clk_stat cleared", clk_stat, 1'b0);
    chk("R6 cpu_on_xtal cleared", cpu_on_xtal, 1'b0);
    chk("R6 crystal still on", xtal_en, 1'b1);
  endtask

  task automatic t_halt();
    goto_state3();
    pulse_halt();
    chk("R7 halted", cpu_halted, 1'b1);
    chk("R7 xtal_en kept", xtal_en, 1'b1);
    chk("R7 hsosc_en kept", hsosc_en, 1'b1);
    chk("R7 cpu_on_xtal kept", cpu_on_xtal, 1'b1);
    tick(); tick();
    chk("R7 still halted", cpu_halted, 1'b1);
    pulse_irq();
    chk("R7 released", cpu_halted, 1'b0);
    chk("R7 back on crystal", cpu_on_xtal, 1'b1);
  endtask

  task automatic t_stop();
    lsosc_keep = 1'b0;
    goto_state2();
    pulse_stop();
    chk("R8 halted", cpu_halted, 1'b1);
    chk("R8 hsosc off", hsosc_en, 1'b0);
    chk("R8 xtal off", xtal_en, 1'b0);
    chk("R12 lsosc off without option", lsosc_en, 1'b0);
    tick();
    chk("R9 stab cleared in stop", stab_done, 1'b0);
    pulse_irq();
    chk("R8 released", cpu_halted, 1'b0);
    chk("R8 xtal back", xtal_en, 1'b1);
    chk("R8 hsosc back", hsosc_en, 1'b1);
    chk("R12 lsosc back", lsosc_en, 1'b1);
    repeat (STAB - 1) tick();
    chk("R9 restart not early", stab_done, 1'b0);
    tick();
    chk("R9 restart on time", stab_done, 1'b1);
    lsosc_keep = 1'b1;
    pulse_stop();
    chk("R12 lsosc kept in stop", lsosc_en, 1'b1);
    pulse_irq();
    lsosc_keep = 1'b0;
    goto_state3();
    pulse_stop();
    chk("R8 stop from state 3", hsosc_en, 1'b0);
    pulse_irq();
    chk("R8 return to state 3", cpu_on_xtal, 1'b1);
    chk("R8 xtal back in state 3", xtal_en, 1'b1);
  endtask

  task automatic t_collisions();
    goto_state2();
    stop_req = 1'b1; irq = 1'b1; tick(); stop_req = 1'b0; irq = 1'b0;
    chk("R10 stop+irq not halted", cpu_halted, 1'b0);
    chk("R10 stop+irq hsosc on", hsosc_en, 1'b1);
    halt_req = 1'b1; irq = 1'b1; tick(); halt_req = 1'b0; irq = 1'b0;
    chk("R10 halt+irq not halted", cpu_halted, 1'b0);
    halt_req = 1'b1; stop_req = 1'b1; tick(); halt_req = 1'b0; stop_req = 1'b0;
    chk("R13 stop wins halted", cpu_halted, 1'b1);
    chk("R13 stop wins hsosc off", hsosc_en, 1'b0);
    pulse_irq();
  endtask

  task automatic t_writes_ignored();
    goto_state2();
    pulse_halt();
    wr_sel(1'b1);
    pulse_irq();
    tick(); tick();
    chk("R14 select write ignored", clk_stat, 1'b0);
    apply_reset();
    pulse_halt();
    wr_xstop(1'b0);
    chk("R14 xtal write ignored in halt", xtal_en, 1'b0);
    pulse_irq();
    chk("R14 xtal still off after release", xtal_en, 1'b0);
  endtask

  task automatic t_reset_sources();
    for (int i = 0; i < NSRC; i++) begin
      goto_state3();
      pulse_stop();
      rst_src = '0; rst_src[i] = 1'b1; tick(); rst_src = '0;
      chk($sformatf("R11 src%0d clk_stat", i), clk_stat, 1'b0);
      chk($sformatf("R11 src%0d cpu_on_xtal", i), cpu_on_xtal, 1'b0);
      chk($sformatf("R11 src%0d xtal_en", i), xtal_en, 1'b0);
      chk($sformatf("R11 src%0d cpu_halted", i), cpu_halted, 1'b0);
      chk($sformatf("R11 src%0d hsosc_en", i), hsosc_en, 1'b1);
      tick();
      chk($sformatf("R11 src%0d stab_done", i), stab_done, 1'b0);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_xtal_start();
    t_sel_pending();
    t_halt();
    t_stop();
    t_collisions();
    t_writes_ignored();
    t_reset_sources();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule